// File: doc/BRIEF.md
# Queued SPI Master

This block is a serial peripheral interface master that works through a list of up to sixteen transfers without help from a processor. Software loads a transmit word and a command byte into each slot it wants to use. It sets the first and last slot to run and pulses `start`. The engine then steps through the slots in order. For each slot it drives the four peripheral chip-select lines from the command byte, clocks the data out MSB first on `mosi`, samples `miso`, and stores the received word in a receive array at the same slot index. The host reads that array back through a separate port.

Each command byte picks the behaviour of its own slot. It chooses between the default 8-bit length and a shared programmable length, and between the standard 17-clock gap after the transfer and a programmable one. It also chooses between a half-period chip-select-to-clock lead and a programmable lead, and whether the chip selects stay driven into the next slot. The queue can wrap from the last slot back to the first. A halt request stops it cleanly at a transfer boundary. A completion flag reports that the last slot has run, and `cur_ptr` always shows the slot being worked on.

Top module: `qspi_master`

## Requirements
- R1: After reset `sck` is low, `pcs` is 4'b1111 (inactive), and `busy`, `done`, `halt_ack` and `irq` are all low.
- R2: A command byte is written with `wr_sel`=1 into the low 8 bits of `wr_data`. Bit 7 is continue, bit 6 is length enable, bit 5 is gap enable, bit 4 is lead enable, and bits 3:0 are the chip-select pattern. During the slot's transfer `pcs` equals bits 3:0. A transmit word is written with `wr_sel`=0.
- R3: `sck` idles low. Data leaves MSB first on `mosi` and `miso` is sampled on each rising `sck`. For a transfer of N bits the low N bits of the transmit word are sent, and the N received bits are stored right-justified (upper bits zero) in the receive array at the slot index.
- R4: With length enable clear a transfer is 8 bits. With it set, `bits_code` 4'b0000 gives 16 bits, 4'b1000 to 4'b1111 give 8 to 15 bits, and the reserved codes 4'b0001 to 4'b0111 give 8 bits.
- R5: Each `sck` half period lasts `baud` clock cycles, so rising edges within a transfer are 2×`baud` cycles apart. When `baud` is 0 a `start` pulse is ignored and no transfer begins.
- R6: With gap enable clear, 17 clock cycles of gap follow a transfer. With it set, `dt_delay` cycles follow instead.
- R7: With lead enable clear, the lead from loading a slot to the first clock phase is `baud` cycles. With it set, the lead is `lead_dly` cycles.
- R8: Slots run from `new_ptr` through `end_ptr`, and the index wraps from 15 to 0. `cur_ptr` equals the slot being transferred.
- R9: With `wrap_en` set, the queue continues at `new_ptr` after the `end_ptr` slot instead of stopping.
- R10: When a slot's continue bit is set, `pcs` keeps its pattern through the following gap. When it is clear, `pcs` returns to 4'b1111 during the gap.
- R11: While `halt_req` is high, the queue stops after the current transfer completes. Later slots are not run and their receive words are left untouched. `halt_ack` is set, and `irq` equals `halt_ack` AND `halt_irq_en`.
- R12: `done` is set when the `end_ptr` slot completes. Both `done` and `halt_ack` are cleared by an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Array write strobe |
| wr_sel | input | 1 | 0 selects the transmit array, 1 selects the command array |
| wr_addr | input | 4 | Slot written |
| wr_data | input | 16 | Write data (command uses bits 7:0) |
| rd_addr | input | 4 | Receive array read slot |
| rd_data | output | 16 | Receive word at `rd_addr` |
| start | input | 1 | Begin running the queue |
| halt_req | input | 1 | Stop at the next transfer boundary |
| halt_irq_en | input | 1 | Enables `irq` from `halt_ack` |
| wrap_en | input | 1 | Return to `new_ptr` after `end_ptr` |
| new_ptr | input | 4 | First slot |
| end_ptr | input | 4 | Last slot |
| baud | input | 8 | Half-period of `sck` in clocks, 0 disables |
| bits_code | input | 4 | Shared transfer length code |
| dt_delay | input | 8 | Programmable post-transfer gap |
| lead_dly | input | 8 | Programmable chip-select lead |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| pcs | output | 4 | Peripheral chip selects |
| busy | output | 1 | Queue running |
| done | output | 1 | Last slot completed |
| halt_ack | output | 1 | Queue stopped on halt request |
| irq | output | 1 | Halt interrupt |
| cur_ptr | output | 4 | Slot being worked on |

## Verification
The bench builds the block with its default sixteen slots and 8-bit baud, gap and lead fields. With 4-bit pointers it can cover every slot, including the 15-to-0 roll-over and a wrap from slots 14–15 back to 14. With 8-bit delay fields the 17-cycle gap can be set against a 100-cycle one, and a 2-cycle lead against a 20-cycle one, measured as differences between `sck` edges. The baud field is varied between 0, 2 and 3. The length code is varied across 16 bits, 11 bits, a reserved value and the default 8.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

  localparam int WORD_W  = 16;
  localparam int CMD_W   = 8;
  localparam int LEN_W   = 5;
  localparam int STD_GAP = 17;

  // command byte field positions
  localparam int CMD_CONT = 7;
  localparam int CMD_LEN  = 6;
  localparam int CMD_GAP  = 5;
  localparam int CMD_LEAD = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LEAD,
    ST_SHIFT,
    ST_GAP
  } qspi_state_e;

  function automatic logic [LEN_W-1:0] xfer_len(input logic len_en, input logic [3:0] code);
    logic [LEN_W-1:0] n;
    if (!len_en)           n = LEN_W'(8);
    else if (code == 4'h0) n = LEN_W'(16);
    else if (code[3])      n = {1'b0, code};
    else                   n = LEN_W'(8);
    return n;
  endfunction

endpackage

// File: rtl/qspi_ram.sv
module qspi_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/qspi_baud.sv
module qspi_baud #(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BAUD_W-1:0] baud,
  output logic              tick
);

  logic [BAUD_W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == baud - BAUD_W'(1));

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + BAUD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
  import qspi_pkg::*;
#(
  parameter int PTR_W   = 4,
  parameter int BAUD_W  = 8,
  parameter int DELAY_W = 8,
  parameter int PCS_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               halt_req,
  input  logic               wrap_en,
  input  logic [PTR_W-1:0]   new_ptr,
  input  logic [PTR_W-1:0]   end_ptr,
  input  logic [BAUD_W-1:0]  baud,
  input  logic [3:0]         bits_code,
  input  logic [DELAY_W-1:0] dt_delay,
  input  logic [DELAY_W-1:0] lead_dly,
  input  logic               tick,
  input  logic [CMD_W-1:0]   cmd_rd,
  input  logic [WORD_W-1:0]  tx_rd,
  input  logic               miso,
  output logic               shift_en,
  output logic [PTR_W-1:0]   ptr,
  output logic               rx_we,
  output logic [WORD_W-1:0]  rx_wdata,
  output logic               sck,
  output logic               mosi,
  output logic [PCS_W-1:0]   pcs,
  output logic               busy,
  output logic               done,
  output logic               halt_ack
);

  qspi_state_e        state_q, state_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [DELAY_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0]   bits_q, bits_d, len_w;
  logic [WORD_W-1:0]  txs_q, txs_d, rxs_q, rxs_d;
  logic               sck_q, sck_d, cont_q, cont_d, gap_q, gap_d;
  logic [PCS_W-1:0]   pcs_q, pcs_d;
  logic               done_q, done_d, halt_q, halt_d, last;

  assign len_w = xfer_len(cmd_rd[CMD_LEN], bits_code);
  assign last  = (ptr_q == end_ptr);

  always_comb begin
    state_d = state_q; ptr_d = ptr_q; cnt_d = cnt_q; bits_d = bits_q;
    txs_d = txs_q; rxs_d = rxs_q; sck_d = sck_q; pcs_d = pcs_q;
    cont_d = cont_q; gap_d = gap_q; done_d = done_q; halt_d = halt_q;
    rx_we = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start && baud != '0) begin
        state_d = ST_LOAD; ptr_d = new_ptr; done_d = 1'b0; halt_d = 1'b0;
      end
      ST_LOAD: begin
        bits_d  = len_w;
        txs_d   = tx_rd << (LEN_W'(16) - len_w);
        rxs_d   = '0;
        pcs_d   = cmd_rd[PCS_W-1:0];
        cont_d  = cmd_rd[CMD_CONT];
        gap_d   = cmd_rd[CMD_GAP];
        cnt_d   = cmd_rd[CMD_LEAD] ? lead_dly : DELAY_W'(baud);
        state_d = ST_LEAD;
      end
      ST_LEAD: begin
        if (cnt_q <= DELAY_W'(1)) state_d = ST_SHIFT;
        else                      cnt_d = cnt_q - DELAY_W'(1);
      end
      ST_SHIFT: if (tick) begin
        if (!sck_q) begin
          sck_d = 1'b1;
          rxs_d = {rxs_q[WORD_W-2:0], miso};
        end else begin
          sck_d  = 1'b0;
          txs_d  = txs_q << 1;
          bits_d = bits_q - LEN_W'(1);
          if (bits_q == LEN_W'(1)) begin
            rx_we = 1'b1;
            if (last) done_d = 1'b1;
            if (halt_req) begin
              halt_d = 1'b1; state_d = ST_IDLE; pcs_d = '1;
            end else if (last && !wrap_en) begin
              state_d = ST_IDLE; pcs_d = '1;
            end else begin
              state_d = ST_GAP;
              ptr_d   = last ? new_ptr : ptr_q + PTR_W'(1);
              cnt_d   = gap_q ? dt_delay : DELAY_W'(STD_GAP);
              if (!cont_q) pcs_d = '1;
            end
          end
        end
      end
      ST_GAP: begin
        if (cnt_q <= DELAY_W'(1)) state_d = ST_LOAD;
        else                      cnt_d = cnt_q - DELAY_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; ptr_q <= '0; cnt_q <= '0; bits_q <= '0;
      txs_q <= '0; rxs_q <= '0; sck_q <= 1'b0; pcs_q <= '1;
      cont_q <= 1'b0; gap_q <= 1'b0; done_q <= 1'b0; halt_q <= 1'b0;
    end else begin
      state_q <= state_d; ptr_q <= ptr_d; cnt_q <= cnt_d; bits_q <= bits_d;
      txs_q <= txs_d; rxs_q <= rxs_d; sck_q <= sck_d; pcs_q <= pcs_d;
      cont_q <= cont_d; gap_q <= gap_d; done_q <= done_d; halt_q <= halt_d;
    end
  end

  assign shift_en = (state_q == ST_SHIFT);
  assign ptr      = ptr_q;
  assign rx_wdata = rxs_q;
  assign sck      = sck_q;
  assign mosi     = txs_q[WORD_W-1];
  assign pcs      = pcs_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign halt_ack = halt_q;

  // R1
  pcs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (pcs_q == '1));
  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_SHIFT) |-> !sck_q);
  // R5
  baud_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && baud == '0) |=> (state_q == ST_IDLE));
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && $past(state_q) == ST_SHIFT) |-> $stable(ptr_q));
  // R11
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_q) |-> (state_q == ST_IDLE));
  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && baud != '0) |=> (!done_q && !halt_q));

endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int BAUD_W  = 8,
  parameter int DELAY_W = 8,
  parameter int PCS_W   = 4,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [PTR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [PTR_W-1:0]   rd_addr,
  output logic [WORD_W-1:0]  rd_data,
  input  logic               start,
  input  logic               halt_req,
  input  logic               halt_irq_en,
  input  logic               wrap_en,
  input  logic [PTR_W-1:0]   new_ptr,
  input  logic [PTR_W-1:0]   end_ptr,
  input  logic [BAUD_W-1:0]  baud,
  input  logic [3:0]         bits_code,
  input  logic [DELAY_W-1:0] dt_delay,
  input  logic [DELAY_W-1:0] lead_dly,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic [PCS_W-1:0]   pcs,
  output logic               busy,
  output logic               done,
  output logic               halt_ack,
  output logic               irq,
  output logic [PTR_W-1:0]   cur_ptr
);

  logic [PTR_W-1:0]  ptr;
  logic [WORD_W-1:0] tx_rd, rx_wdata;
  logic [CMD_W-1:0]  cmd_rd;
  logic              rx_we, tick, shift_en;

  qspi_ram #(.W(WORD_W), .DEPTH(ENTRIES)) u_tx_ram (
    .clk(clk), .we(wr_en && !wr_sel), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ptr), .rdata(tx_rd));

  qspi_ram #(.W(CMD_W), .DEPTH(ENTRIES)) u_cmd_ram (
    .clk(clk), .we(wr_en && wr_sel), .waddr(wr_addr), .wdata(wr_data[CMD_W-1:0]),
    .raddr(ptr), .rdata(cmd_rd));

  qspi_ram #(.W(WORD_W), .DEPTH(ENTRIES)) u_rx_ram (
    .clk(clk), .we(rx_we), .waddr(ptr), .wdata(rx_wdata),
    .raddr(rd_addr), .rdata(rd_data));

  qspi_baud #(.BAUD_W(BAUD_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .en(shift_en), .baud(baud), .tick(tick));

  qspi_engine #(.PTR_W(PTR_W), .BAUD_W(BAUD_W), .DELAY_W(DELAY_W), .PCS_W(PCS_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .halt_req(halt_req), .wrap_en(wrap_en),
    .new_ptr(new_ptr), .end_ptr(end_ptr), .baud(baud), .bits_code(bits_code),
    .dt_delay(dt_delay), .lead_dly(lead_dly), .tick(tick), .cmd_rd(cmd_rd),
    .tx_rd(tx_rd), .miso(miso), .shift_en(shift_en), .ptr(ptr), .rx_we(rx_we),
    .rx_wdata(rx_wdata), .sck(sck), .mosi(mosi), .pcs(pcs), .busy(busy),
    .done(done), .halt_ack(halt_ack));

  assign irq     = halt_ack && halt_irq_en;
  assign cur_ptr = ptr;

endmodule

// File: tb/qspi_master_bench.sv
module qspi_master_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wr_en = 0, wr_sel = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0, new_ptr = 0, end_ptr = 0, bits_code = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic        start = 0, halt_req = 0, halt_irq_en = 0, wrap_en = 0;
  logic [7:0]  baud = 8'd2, dt_delay = 8'd30, lead_dly = 8'd5;
  logic        miso, sck, mosi, busy, done, halt_ack, irq, miso_inv = 1'b1;
  logic [3:0]  pcs, cur_ptr;

  assign miso = miso_inv ? ~mosi : mosi;

  qspi_master u_qspi_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .start(start),
    .halt_req(halt_req), .halt_irq_en(halt_irq_en), .wrap_en(wrap_en),
    .new_ptr(new_ptr), .end_ptr(end_ptr), .baud(baud), .bits_code(bits_code),
    .dt_delay(dt_delay), .lead_dly(lead_dly), .miso(miso), .sck(sck), .mosi(mosi),
    .pcs(pcs), .busy(busy), .done(done), .halt_ack(halt_ack), .irq(irq),
    .cur_ptr(cur_ptr));

  typedef struct {
    int          len;
    logic [15:0] tx;
    logic [3:0]  pcs;
    logic [3:0]  ptr;
    logic        cont;
  } xfer_t;

  xfer_t       exp_q[$];
  logic [15:0] tx_m [16];
  logic [7:0]  cmd_m [16];
  logic [15:0] rx_exp [16];
  int n_chk = 0, n_fail = 0;
  int cyc = 0, rises = 0, bitcnt = 0, last_gap = 0, end_rise = 0, prev_rise = 0;
  logic sck_prev = 1'b0, idle_seen = 1'b0, prev_cont = 1'b0, new_run = 1'b1;
  logic [15:0] word = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R4: length from the length-enable bit and the shared code
  function automatic int exp_len(input logic [7:0] c, input logic [3:0] code);
    if (!c[6]) return 8;
    if (code == 4'h0) return 16;
    if (code[3]) return int'(code);
    return 8;
  endfunction

  function automatic logic [15:0] mask(input int n);
    return (n == 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  task automatic set_entry(input int i, input logic [15:0] tx, input logic [7:0] c);
    @(negedge clk);
    wr_en = 1; wr_sel = 0; wr_addr = 4'(i); wr_data = tx;
    @(negedge clk);
    wr_sel = 1; wr_data = {8'h00, c};
    @(negedge clk);
    wr_en = 0;
    tx_m[i] = tx; cmd_m[i] = c;
  endtask

  task automatic push(input int p);
    xfer_t it;
    it.len = exp_len(cmd_m[p], bits_code);
    it.tx = tx_m[p] & mask(it.len);
    it.pcs = cmd_m[p][3:0];
    it.ptr = 4'(p);
    it.cont = cmd_m[p][7];
    exp_q.push_back(it);
    rx_exp[p] = miso_inv ? (~tx_m[p] & mask(it.len)) : it.tx;
  endtask

  task automatic kick();
    new_run = 1'b1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    // R12: start clears the flags
    chk(done == 0 && halt_ack == 0, "R12 flags cleared by start", {done, halt_ack}, 0);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
  endtask

  task automatic run(input int np, input int ep);
    int p = np;
    int r0, nb = 0;
    forever begin
      push(p); nb += exp_len(cmd_m[p], bits_code);
      if (p == ep) break;
      p = (p + 1) % 16;
    end
    new_ptr = 4'(np); end_ptr = 4'(ep);
    r0 = rises;
    kick();
    wait_idle();
    chk(exp_q.size() == 0, "R8 all queued slots ran", exp_q.size(), 0);
    chk(rises - r0 == nb, "R4 total sck pulses", rises - r0, nb);
    chk(done == 1 && busy == 0, "R12 done after last slot", {done, busy}, 2'b10);
    chk(pcs == 4'hF, "R10 pcs inactive after queue", pcs, 4'hF);
  endtask

  task automatic chk_rx(input int i);
    @(negedge clk); rd_addr = 4'(i);
    #2;
    chk(rd_data == rx_exp[i], $sformatf("R3 rx slot %0d", i), rd_data, rx_exp[i]);
  endtask

  // monitor: compares observed transfers against the scoreboard
  always @(negedge clk) begin
    cyc++;
    if (pcs == 4'hF) idle_seen = 1'b1;
    if (sck && !sck_prev) begin
      rises++;
      if (bitcnt == 0) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected transfer", cur_ptr, 0);
        else begin
          chk(pcs == exp_q[0].pcs, "R2 pcs pattern", pcs, exp_q[0].pcs);
          chk(cur_ptr == exp_q[0].ptr, "R8 slot order", cur_ptr, exp_q[0].ptr);
        end
        if (!new_run) begin
          last_gap = cyc - end_rise;
          // R10: inactive pcs seen in the gap iff continue was clear
          chk(idle_seen == !prev_cont, "R10 continue handling", idle_seen, !prev_cont);
        end
        new_run = 1'b0;
        word = 0;
      end else begin
        chk(cyc - prev_rise == 2 * int'(baud), "R5 sck period", cyc - prev_rise, 2 * baud);
      end
      prev_rise = cyc;
      word = {word[14:0], mosi};
      bitcnt++;
      if (exp_q.size() != 0 && bitcnt == exp_q[0].len) begin
        chk(word == exp_q[0].tx, "R3 mosi word", word, exp_q[0].tx);
        prev_cont = exp_q[0].cont;
        void'(exp_q.pop_front());
        bitcnt = 0;
        end_rise = cyc;
        idle_seen = 1'b0;
      end
    end
    sck_prev = sck;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int g0, g1, g2, r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(sck == 0 && pcs == 4'hF, "R1 reset outputs", {sck, pcs}, 5'h0F);
    chk({busy, done, halt_ack, irq} == 0, "R1 reset flags", {busy, done, halt_ack, irq}, 0);

    // R2 R3 R4 R10: mixed lengths, continue on slot 0, inverted echo
    set_entry(0, 16'hA5C3, 8'b1000_1110);
    set_entry(1, 16'h1234, 8'b0100_1101);
    set_entry(2, 16'h00F0, 8'b0000_1011);
    set_entry(3, 16'hBEEF, 8'b0110_0111);
    bits_code = 4'h0; baud = 2; miso_inv = 1;
    run(0, 3);
    for (int i = 0; i < 4; i++) chk_rx(i);

    // R4 R5 R7: 11-bit code, baud 3, lead from lead_dly, loopback
    set_entry(4, 16'h07FF, 8'b0100_1110);
    set_entry(5, 16'h0555, 8'b1100_1100);
    set_entry(6, 16'hFFFF, 8'b0001_0000);
    bits_code = 4'b1011; baud = 3; miso_inv = 0;
    run(4, 6);
    for (int i = 4; i < 7; i++) chk_rx(i);

    // R4: reserved code falls back to 8 bits
    set_entry(7, 16'h3CFF, 8'b0100_1110);
    bits_code = 4'b0011; baud = 2;
    run(7, 7);
    chk_rx(7);

    // R6 R7: gap and lead measured between slots 8 and 9
    dt_delay = 100; lead_dly = 20;
    set_entry(8, 16'h0081, 8'b0000_0111);
    set_entry(9, 16'h0042, 8'b0000_0111);
    run(8, 9); g0 = last_gap;
    set_entry(8, 16'h0081, 8'b0010_0111);
    run(8, 9); g1 = last_gap;
    chk(g1 - g0 == 83, "R6 programmable gap vs 17", g1 - g0, 83);
    set_entry(8, 16'h0081, 8'b0000_0111);
    set_entry(9, 16'h0042, 8'b0001_0111);
    run(8, 9); g2 = last_gap;
    chk(g2 - g0 == 18, "R7 programmable lead vs baud", g2 - g0, 18);

    // R8: index rolls over 15 -> 0
    set_entry(14, 16'h1111, 8'b0000_1110);
    set_entry(15, 16'h2222, 8'b1000_1101);
    set_entry(0, 16'h3333, 8'b0000_1011);
    set_entry(1, 16'h4444, 8'b0000_0111);
    miso_inv = 1;
    run(14, 1);
    chk_rx(14); chk_rx(15); chk_rx(0); chk_rx(1);

    // R11: halt while running slots 0..3 stops after slot 0
    set_entry(1, 16'h5A5A, 8'b0000_0111);
    halt_irq_en = 0; halt_req = 1;
    new_ptr = 0; end_ptr = 3;
    push(0);
    kick();
    wait_idle();
    halt_req = 0;
    chk(halt_ack == 1 && done == 0, "R11 halt_ack without done", {halt_ack, done}, 2'b10);
    chk(irq == 0, "R11 irq masked", irq, 0);
    chk(exp_q.size() == 0, "R11 only slot 0 ran", exp_q.size(), 0);
    chk_rx(0); chk_rx(1);

    // R9 R11: wrap over 14..15, halt once done is seen
    halt_irq_en = 1; wrap_en = 1;
    new_ptr = 14; end_ptr = 15;
    push(14); push(15); push(14);
    kick();
    for (int k = 0; k < 20000 && !done; k++) @(negedge clk);
    halt_req = 1;
    wait_idle();
    halt_req = 0; wrap_en = 0;
    chk(exp_q.size() == 0, "R9 wrapped back to new_ptr", exp_q.size(), 0);
    chk(halt_ack == 1 && irq == 1, "R11 halt with irq", {halt_ack, irq}, 2'b11);
    chk(done == 1, "R12 done on wrap pass", done, 1);

    // R12: a new start clears halt_ack
    run(2, 2);
    chk(halt_ack == 0 && irq == 0, "R12 halt_ack cleared", {halt_ack, irq}, 0);

    // R5: baud zero ignores start
    baud = 0; r0 = rises;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    chk(busy == 0 && rises == r0, "R5 baud zero ignored", {busy, 8'(rises - r0)}, 0);
    chk(pcs == 4'hF, "R5 pcs idle with baud zero", pcs, 4'hF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule